// File: doc/BRIEF.md
# Programmable multi-mode word shifter

This block moves the bits of an N-bit data word by a programmable distance. It has no clock. A two-bit kind input picks one of four operations:

- **Logical:** vacated positions are filled with zeros.
- **Arithmetic:** a right move copies the sign bit into the vacated positions.
- **Circular:** bits that leave one end come back in at the other end.
- **Funnel:** the block places a second word above the data word and takes an N-bit window out of the pair.

A direction input picks a left or a right move for the first three kinds. The funnel kind does not use it.

The distance input is log2(N) bits wide. It is decoded into a one-hot row of distance selects, and exactly one of them drives the output through an AND-OR barrel array.

All four kinds use the same array. A small preparation stage feeds the array a low word and a high word that depend on the kind. Left moves are done as right moves on the bit-reversed word, and the output is reversed back.

The block has no states and no state register. Its behaviour is fully set by the current inputs. It fits in a datapath wherever one cycle of combinational delay is acceptable.

Top module: `shifter_top`

## Requirements
- R1: With a distance of 0, the output equals `data_a` in every kind and in both directions. In the funnel kind, `data_b` has no effect at distance 0.
- R2: Kind 2'b00 with `dir_left`=0 gives `data_a` moved right by `shamt`. The top `shamt` bits are filled with 0.
- R3: Kind 2'b01 with `dir_left`=0 gives `data_a` moved right by `shamt`. The vacated high bits are copies of `data_a[N-1]`. For example, N=8, a=8'h80, shamt=3 gives 8'hF0.
- R4: Kinds 2'b00 and 2'b01 with `dir_left`=1 give `data_a` moved left by `shamt` with zeros in the low bits. This equals `data_a`·2^shamt mod 2^N.
- R5: Kind 2'b10 with `dir_left`=0 rotates `data_a` right by `shamt`. Bit i of the output is `data_a[(i+shamt) mod N]`.
- R6: Kind 2'b10 with `dir_left`=1 rotates `data_a` left by `shamt`. Bit i of the output is `data_a[(i-shamt) mod N]`.
- R7: Kind 2'b11 gives bits [shamt+N-1:shamt] of the 2N-bit pair {`data_b`,`data_a`}. `dir_left` has no effect in this kind.
- R8: The kind codes are: 2'b00 logical, 2'b01 arithmetic, 2'b10 circular, 2'b11 funnel. `dir_left`=1 means left and 0 means right. For example, a=8'h80, shamt=1, right gives 8'h40 for code 2'b00 and 8'hC0 for code 2'b01.
- R9: Exactly one distance select is active for any `shamt`, so each distance gives a distinct result. A circular right rotation of 8'h01 by k sets only bit (N-k) mod N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_a | input | N | Word to be moved; low half of the funnel pair |
| data_b | input | N | High half of the funnel pair |
| shamt | input | log2(N) | Shift distance, or window offset in funnel kind |
| dir_left | input | 1 | 1 = left, 0 = right; unused in funnel kind |
| kind | input | 2 | Operation code (see R8) |
| data_y | output | N | Result word |

## Verification
The bench runs every kind, direction and distance over a set of data words, and compares each result with a model built from plain shift, arithmetic-shift and concatenation operators.

The data words are chosen to separate the kinds from one another:
- A lone top bit separates the sign fill from the zero fill.
- A lone low bit and walking ones show which distance select fired and where rotated bits re-enter.
- Alternating and asymmetric patterns catch swapped or mirrored lanes.
- All-ones and all-zeros patterns catch a stuck fill value.

In the funnel kind, the second word is always different from the first. This makes the window position visible, and it lets the bench confirm that the direction input is ignored there.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    typedef enum logic [1:0] {
        KIND_LOGIC  = 2'b00,
        KIND_ARITH  = 2'b01,
        KIND_CIRC   = 2'b10,
        KIND_FUNNEL = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/shift_sel_decode.sv
module shift_sel_decode #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic [AW-1:0] amt,
    output logic [N-1:0]  sel
);

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (amt == AW'(i)) sel[i] = 1'b1;
        end
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot(sel)); // R9
        if (amt == '0) begin
            AST_SEL_ZERO: assert (sel[0]); // R1
        end
    end

endmodule

// File: rtl/shift_operand_prep.sv
module shift_operand_prep
    import shifter_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  shift_kind_e  kind,
    input  logic         dir_left,
    output logic [N-1:0] lo_word,
    output logic [N-1:0] hi_word,
    output logic         flip
);

    logic [N-1:0] a_rev;

    always_comb begin
        for (int i = 0; i < N; i++) a_rev[i] = a[N-1-i];
    end

    always_comb begin
        lo_word = a;
        hi_word = '0;
        flip    = 1'b0;
        unique case (kind)
            KIND_LOGIC: begin
                if (dir_left) begin
                    lo_word = a_rev;
                    flip    = 1'b1;
                end
            end
            KIND_ARITH: begin
                if (dir_left) begin
                    lo_word = a_rev;
                    flip    = 1'b1;
                end else begin
                    hi_word = {N{a[N-1]}};
                end
            end
            KIND_CIRC: begin
                if (dir_left) begin
                    lo_word = a_rev;
                    hi_word = a_rev;
                    flip    = 1'b1;
                end else begin
                    hi_word = a;
                end
            end
            KIND_FUNNEL: begin
                hi_word = b;
            end
            default: begin
                lo_word = a;
            end
        endcase
    end

    always_comb begin
        if (kind == KIND_FUNNEL) begin
            AST_FUNNEL_NO_FLIP: assert (!flip); // R7
        end
    end

endmodule

// File: rtl/shift_barrel_array.sv
module shift_barrel_array #(
    parameter int N = 8
) (
    input  logic [N-1:0] lo_word,
    input  logic [N-1:0] hi_word,
    input  logic [N-1:0] sel,
    output logic [N-1:0] win
);

    localparam int EW = 2 * N;

    logic [EW-1:0] ext;
    logic [N-1:0]  lane [N];

    assign ext = {hi_word, lo_word};

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign lane[k] = ext[k +: N] & {N{sel[k]}};
    end

    always_comb begin
        win = '0;
        for (int k = 0; k < N; k++) win = win | lane[k];
    end

    always_comb begin
        if (sel[0]) begin
            AST_PASS_LOW: assert (win == lo_word); // R1
        end
        if (sel[N-1]) begin
            AST_TOP_LANE: assert (win[0] == lo_word[N-1]); // R9
        end
    end

endmodule

// File: rtl/shifter_top.sv
module shifter_top
    import shifter_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]         data_a,
    input  logic [N-1:0]         data_b,
    input  logic [$clog2(N)-1:0] shamt,
    input  logic                 dir_left,
    input  logic [1:0]           kind,
    output logic [N-1:0]         data_y
);

    localparam int AW = $clog2(N);

    shift_kind_e  kind_e;
    logic [N-1:0] sel;
    logic [N-1:0] lo_word;
    logic [N-1:0] hi_word;
    logic         flip;
    logic [N-1:0] win;

    assign kind_e = shift_kind_e'(kind);

    shift_sel_decode #(.N(N), .AW(AW)) u_dec (
        .amt (shamt),
        .sel (sel)
    );

    shift_operand_prep #(.N(N)) u_prep (
        .a        (data_a),
        .b        (data_b),
        .kind     (kind_e),
        .dir_left (dir_left),
        .lo_word  (lo_word),
        .hi_word  (hi_word),
        .flip     (flip)
    );

    shift_barrel_array #(.N(N)) u_bar (
        .lo_word (lo_word),
        .hi_word (hi_word),
        .sel     (sel),
        .win     (win)
    );

    always_comb begin
        if (flip) begin
            for (int i = 0; i < N; i++) data_y[i] = win[N-1-i];
        end else begin
            data_y = win;
        end
    end

    always_comb begin
        if (shamt == '0) begin
            AST_ZERO_IDENT: assert (data_y == data_a); // R1
        end
        if (kind_e == KIND_ARITH && !dir_left) begin
            AST_SIGN_KEPT: assert (data_y[N-1] == data_a[N-1]); // R3
        end
        if ((kind_e == KIND_LOGIC || kind_e == KIND_ARITH) && dir_left && shamt != '0) begin
            AST_LEFT_LOW_ZERO: assert (data_y[0] == 1'b0); // R4
        end
        if (kind_e == KIND_LOGIC && !dir_left && shamt != '0) begin
            AST_RIGHT_TOP_ZERO: assert (data_y[N-1] == 1'b0); // R2
        end
        if (kind_e == KIND_CIRC) begin
            AST_ROT_KEEPS_ONES: assert ($countones(data_y) == $countones(data_a)); // R5 R6
        end
    end

endmodule

// File: tb/shifter_top_tb.sv
module shifter_top_tb;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_a = '0;
    logic [7:0] data_b = '0;
    logic [2:0] shamt = '0;
    logic       dir_left = 1'b0;
    logic [1:0] kind = '0;
    logic [7:0] data_y;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shifter_top #(.N(N)) u_dut (
        .data_a   (data_a),
        .data_b   (data_b),
        .shamt    (shamt),
        .dir_left (dir_left),
        .kind     (kind),
        .data_y   (data_y)
    );

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input int k, input logic dl, input int amt);
        logic [15:0] pair;
        logic signed [7:0] sa;
        sa = a;
        case (k)
            0: return dl ? (a << amt) : (a >> amt);
            1: return dl ? (a << amt) : 8'(sa >>> amt);
            2: begin
                pair = {a, a};
                if (dl) begin
                    pair = pair << amt;
                    return pair[15:8];
                end
                pair = pair >> amt;
                return pair[7:0];
            end
            default: begin
                pair = {b, a} >> amt;
                return pair[7:0];
            end
        endcase
    endfunction

    function automatic string tag(input int k, input logic dl, input int amt);
        if (amt == 0) return "R1";
        case (k)
            0: return dl ? "R4" : "R2";
            1: return dl ? "R4" : "R3";
            2: return dl ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_run++;
        if (data_y !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h kind=%0d dir=%0b amt=%0d got %h expected %h",
                     req, data_a, data_b, kind, dir_left, shamt, data_y, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input int k,
                         input logic dl, input int amt);
        @(negedge clk);
        data_a = a; data_b = b; kind = 2'(k); dir_left = dl; shamt = 3'(amt);
        #2;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] pats [12];
        pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'h96, 8'h7F,
                 8'hC3, 8'h10, 8'h3C, 8'hE1};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle inputs: all-zero word in, zero out
        apply(8'h00, 8'h00, 0, 1'b0, 0);
        check("R1", 8'h00);

        // R8: code distinction between logical and arithmetic fill
        apply(8'h80, 8'h00, 0, 1'b0, 1);
        check("R8", 8'h40);
        apply(8'h80, 8'h00, 1, 1'b0, 1);
        check("R8", 8'hC0);
        apply(8'h80, 8'h00, 1, 1'b0, 3);
        check("R3", 8'hF0);

        // R9: each distance lights a distinct single bit
        for (int amt = 0; amt < N; amt++) begin
            apply(8'h01, 8'h00, 2, 1'b0, amt);
            check("R9", 8'(1 << ((N - amt) % N)));
        end

        // exhaustive kinds, directions, distances over patterns
        for (int p = 0; p < 12; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int amt = 0; amt < N; amt++) begin
                        logic [7:0] bw;
                        bw = ~pats[p] ^ 8'h69;
                        apply(pats[p], bw, k, d[0], amt);
                        check(tag(k, d[0], amt), model(pats[p], bw, k, d[0], amt));
                    end
                end
            end
        end

        // R7: direction ignored in funnel kind, compare against fixed window
        for (int amt = 0; amt < N; amt++) begin
            apply(8'h3C, 8'hA1, 3, 1'b1, amt);
            check("R7", model(8'h3C, 8'hA1, 3, 1'b0, amt));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule